// File: doc/BRIEF.md
# Interrupt Routing Table Register Front End

This block is the software-visible face of an I/O interrupt routing controller. A bus master reaches all of its state through two 32-bit registers at the bottom of a 256-byte window. It writes an index into the select register. It then reads or writes the data window, and the access lands on whatever the index names. The index can name the controller's identifier, its version word, an arbitration identifier, or one half of a 64-bit routing entry. There is one routing entry per interrupt pin.

The routing table itself lives here and is exported to the delivery logic. The delivery logic can set or clear each entry's remote-pending flag. This block raises two kinds of one-cycle event: a pulse when a write flips an entry's mask bit, and a service request when a rewritten level-triggered entry has a live request on its pin. Delivery and end-of-interrupt handling are not part of this block.

The bus is a single-cycle request port with valid, write, address, byte size and a 32-bit data lane that carries the low word of any access. Every access that falls inside the window is answered one cycle later with a response-valid strobe and, for reads, the data.

Top module: `irq_route_regs`

## Requirements
- R1: After reset, every entry reads 0x00010000 in its low half and 0 in its high half (mask bit 16 set, all else clear). The select register reads 0 and the identifier is 0.
- R2: Only address bits 7:0 are decoded inside the window. Offset 0x00 is the select register, which is readable and writable. Offset 0x10 is the data window. Reads at any other offset return 0, and writes there change nothing.
- R3: Select value 0x01 reads (NPINS-1) in bits 23:16 and VERSION in bits 7:0, which is 0x00170011 by default. Writes through it are ignored.
- R4: A window write with select 0x00 stores data bits 27:24 as the identifier. Select 0x00 and select 0x02 both read the identifier back in bits 27:24, with all other bits 0. Writes with select 0x02 are ignored.
- R5: For a select value s of 0x10 or above, the entry index is (s-0x10)>>1. An even s reaches entry bits 31:0 and an odd s reaches entry bits 63:32. Both halves read back what was written, except for remote-pending at bit 14.
- R6: A low-half write forces remote-pending (bit 14) to 0 whatever the data holds. A high-half write leaves it unchanged.
- R7: A window write whose index is NPINS or more changes nothing. A window read at such an index returns 0, and so does a read with select 0x03 to 0x0F.
- R8: Writes are performed only when the size is 4 or 8 bytes. Other sizes are still answered but change nothing.
- R9: A write that changes an entry's mask bit (bit 16) gives mask_chg_valid high for exactly the next cycle, with the pin index and the new mask value. A write that leaves the mask bit unchanged gives no pulse.
- R10: One cycle after any entry write, svc_valid pulses with that pin's index if the written entry has trigger mode bit 15 equal to 1 and pin_req for that pin was high during the write.
- R11: An access with address in [BASE_ADDR, BASE_ADDR+0x100) gets rsp_valid in the next cycle. For reads, rsp_rdata then carries the data; for writes it carries 0. An access outside that range gets no response and has no effect.
- R12: rp_set sets and rp_clr clears an entry's remote-pending flag at the next edge, and clear wins when both are asserted. A low-half write in the same cycle as rp_set leaves the flag at 0.
- R13: tbl_out presents entry i at bits [64*i+63 : 64*i], laid out as follows. Bits 7:0 are the vector and bits 10:8 the delivery mode. Bit 11 is the destination mode, bit 13 the polarity and bit 14 remote-pending. Bit 15 is the trigger mode and bit 16 the mask. Bits 63:56 are the destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 32 | Low word of write data |
| rsp_valid | output | 1 | Response for a claimed access, one cycle later |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| pin_req | input | NPINS | Current request level per pin |
| rp_set | input | NPINS | Set remote-pending per pin |
| rp_clr | input | NPINS | Clear remote-pending per pin |
| tbl_out | output | 64*NPINS | Whole routing table |
| mask_chg_valid | output | 1 | Mask bit changed pulse |
| mask_chg_pin | output | IDX_W | Pin whose mask changed |
| mask_chg_val | output | 1 | New mask value |
| svc_valid | output | 1 | Service request pulse |
| svc_pin | output | IDX_W | Pin to re-check |

## Verification
The hardest situation to bring about is a low-half write that lands in the same cycle as a delivery-side set of remote-pending on the same pin. A close second is a level entry rewritten while its request line is high. Both need the select register, the pin inputs and the bus write lined up in a single cycle. The stimulus drives the remote-pending inputs as part of the same bus cycle task, and it holds pin_req across random writes. A random sweep of select values past the last valid index checks the discard path. Directed cases pin down the collision and the mask-toggle pulse.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    // One routing entry, most significant field first
    typedef struct packed {
        logic [7:0]  dest;
        logic [38:0] rsvd;
        logic        mask;
        logic        trig;
        logic        rpend;
        logic        pol;
        logic        dstat;
        logic        dmode;
        logic [2:0]  dlv;
        logic [7:0]  vec;
    } route_ent_t;

    localparam int ENT_W = 64;
    localparam int WIN_BYTES = 256;

    localparam logic [7:0] OFS_SELECT = 8'h00;
    localparam logic [7:0] OFS_WINDOW = 8'h10;

    localparam logic [31:0] SEL_ID       = 32'h0000_0000;
    localparam logic [31:0] SEL_VER      = 32'h0000_0001;
    localparam logic [31:0] SEL_ARB      = 32'h0000_0002;
    localparam logic [31:0] SEL_TBL_BASE = 32'h0000_0010;

    typedef enum logic [1:0] {
        OK_SELECT,
        OK_WINDOW,
        OK_OTHER
    } ofs_kind_t;

    typedef enum logic [2:0] {
        TGT_ID,
        TGT_VER,
        TGT_ARB,
        TGT_ENT,
        TGT_NONE
    } win_tgt_t;

    function automatic route_ent_t ent_reset_value();
        route_ent_t r;
        r = '0;
        r.mask = 1'b1;
        return r;
    endfunction

    // Replace one 32-bit half; a low-half write drops remote-pending
    function automatic route_ent_t ent_write_half(route_ent_t old, logic hi,
                                                  logic [31:0] d);
        logic [ENT_W-1:0] v;
        route_ent_t r;
        v = old;
        if (hi) begin
            v[63:32] = d;
        end else begin
            v[31:0] = d;
        end
        r = route_ent_t'(v);
        if (!hi) begin
            r.rpend = 1'b0;
        end
        return r;
    endfunction

    function automatic logic [31:0] ent_read_half(route_ent_t e, logic hi);
        logic [ENT_W-1:0] v;
        v = e;
        return hi ? v[63:32] : v[31:0];
    endfunction

endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode
    import irq_route_pkg::*;
#(
    parameter int              NPINS     = 24,
    parameter int              ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h4000_1000,
    localparam int             IDX_W     = $clog2(NPINS)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       sel,
    output logic              in_win,
    output ofs_kind_t         ofs_kind,
    output win_tgt_t          tgt,
    output logic [IDX_W-1:0]  ent_idx,
    output logic              ent_hi
);

    localparam logic [ADDR_W:0] WIN_LO = {1'b0, BASE_ADDR};
    localparam logic [ADDR_W:0] WIN_HI = {1'b0, BASE_ADDR} + (ADDR_W+1)'(WIN_BYTES);

    logic [ADDR_W:0] addr_x;
    logic [7:0]      ofs;
    logic [31:0]     rel;
    logic [31:0]     full_idx;

    assign addr_x = {1'b0, addr};
    assign in_win = (addr_x >= WIN_LO) && (addr_x < WIN_HI);
    assign ofs    = addr[7:0];

    always_comb begin
        if (ofs == OFS_SELECT) begin
            ofs_kind = OK_SELECT;
        end else if (ofs == OFS_WINDOW) begin
            ofs_kind = OK_WINDOW;
        end else begin
            ofs_kind = OK_OTHER;
        end
    end

    assign rel      = sel - SEL_TBL_BASE;
    assign full_idx = rel >> 1;
    assign ent_idx  = full_idx[IDX_W-1:0];
    assign ent_hi   = sel[0];

    always_comb begin
        if (sel == SEL_ID) begin
            tgt = TGT_ID;
        end else if (sel == SEL_VER) begin
            tgt = TGT_VER;
        end else if (sel == SEL_ARB) begin
            tgt = TGT_ARB;
        end else if (sel >= SEL_TBL_BASE && full_idx < 32'(NPINS)) begin
            tgt = TGT_ENT;
        end else begin
            tgt = TGT_NONE;
        end
    end

endmodule

// File: rtl/irq_route_table.sv
module irq_route_table
    import irq_route_pkg::*;
#(
    parameter int  NPINS = 24,
    localparam int IDX_W = $clog2(NPINS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_hi,
    input  logic [31:0]      wr_data,
    input  logic [NPINS-1:0] rp_set,
    input  logic [NPINS-1:0] rp_clr,
    output route_ent_t       ents [NPINS]
);

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        route_ent_t nxt;

        // Delivery-side flag updates first, then the bus write on top
        always_comb begin
            nxt = ents[i];
            if (rp_set[i]) begin
                nxt.rpend = 1'b1;
            end
            if (rp_clr[i]) begin
                nxt.rpend = 1'b0;
            end
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                nxt = ent_write_half(nxt, wr_hi, wr_data);
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                ents[i] <= ent_reset_value();
            end else begin
                ents[i] <= nxt;
            end
        end
    end

endmodule

// File: rtl/irq_route_events.sv
module irq_route_events
    import irq_route_pkg::*;
#(
    parameter int  NPINS = 24,
    localparam int IDX_W = $clog2(NPINS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_hi,
    input  logic [31:0]      wr_data,
    input  route_ent_t       old_ent,
    input  logic [NPINS-1:0] pin_req,
    output logic             mask_chg_valid,
    output logic [IDX_W-1:0] mask_chg_pin,
    output logic             mask_chg_val,
    output logic             svc_valid,
    output logic [IDX_W-1:0] svc_pin
);

    route_ent_t new_ent;
    logic       req_bit;
    logic       mask_flip;
    logic       want_svc;

    assign new_ent   = ent_write_half(old_ent, wr_hi, wr_data);
    assign req_bit   = |(pin_req & (NPINS'(1) << wr_idx));
    assign mask_flip = wr_en && (new_ent.mask != old_ent.mask);
    assign want_svc  = wr_en && new_ent.trig && req_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_chg_valid <= 1'b0;
            mask_chg_pin   <= '0;
            mask_chg_val   <= 1'b0;
            svc_valid      <= 1'b0;
            svc_pin        <= '0;
        end else begin
            mask_chg_valid <= mask_flip;
            svc_valid      <= want_svc;
            if (mask_flip) begin
                mask_chg_pin <= wr_idx;
                mask_chg_val <= new_ent.mask;
            end
            if (want_svc) begin
                svc_pin <= wr_idx;
            end
        end
    end

endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int                NPINS     = 24,
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h4000_1000,
    parameter logic [7:0]        VERSION   = 8'h11,
    localparam int               IDX_W     = $clog2(NPINS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [3:0]             req_size,
    input  logic [31:0]            req_wdata,
    output logic                   rsp_valid,
    output logic [31:0]            rsp_rdata,
    input  logic [NPINS-1:0]       pin_req,
    input  logic [NPINS-1:0]       rp_set,
    input  logic [NPINS-1:0]       rp_clr,
    output logic [NPINS*ENT_W-1:0] tbl_out,
    output logic                   mask_chg_valid,
    output logic [IDX_W-1:0]       mask_chg_pin,
    output logic                   mask_chg_val,
    output logic                   svc_valid,
    output logic [IDX_W-1:0]       svc_pin
);

    localparam logic [31:0] VER_WORD = {8'h00, 8'(NPINS - 1), 8'h00, VERSION};

    logic [31:0]      sel_q;
    logic [3:0]       id_q;
    logic             in_win;
    ofs_kind_t        ofs_kind;
    win_tgt_t         tgt;
    logic [IDX_W-1:0] ent_idx;
    logic             ent_hi;
    route_ent_t       ents [NPINS];
    route_ent_t       cur_ent;

    logic        claim;
    logic        size_ok;
    logic        wr_ok;
    logic        sel_wr;
    logic        win_wr;
    logic        ent_wr;
    logic        id_wr;
    logic [31:0] id_word;
    logic [31:0] win_word;
    logic [31:0] rd_word;

    irq_route_decode #(
        .NPINS    (NPINS),
        .ADDR_W   (ADDR_W),
        .BASE_ADDR(BASE_ADDR)
    ) u_dec (
        .addr    (req_addr),
        .sel     (sel_q),
        .in_win  (in_win),
        .ofs_kind(ofs_kind),
        .tgt     (tgt),
        .ent_idx (ent_idx),
        .ent_hi  (ent_hi)
    );

    assign claim   = req_valid && in_win;
    assign size_ok = (req_size == 4'd4) || (req_size == 4'd8);
    assign wr_ok   = claim && req_write && size_ok;
    assign sel_wr  = wr_ok && (ofs_kind == OK_SELECT);
    assign win_wr  = wr_ok && (ofs_kind == OK_WINDOW);
    assign ent_wr  = win_wr && (tgt == TGT_ENT);
    assign id_wr   = win_wr && (tgt == TGT_ID);

    irq_route_table #(
        .NPINS(NPINS)
    ) u_tbl (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (ent_wr),
        .wr_idx (ent_idx),
        .wr_hi  (ent_hi),
        .wr_data(req_wdata),
        .rp_set (rp_set),
        .rp_clr (rp_clr),
        .ents   (ents)
    );

    assign cur_ent = ents[ent_idx];

    irq_route_events #(
        .NPINS(NPINS)
    ) u_evt (
        .clk           (clk),
        .rst           (rst),
        .wr_en         (ent_wr),
        .wr_idx        (ent_idx),
        .wr_hi         (ent_hi),
        .wr_data       (req_wdata),
        .old_ent       (cur_ent),
        .pin_req       (pin_req),
        .mask_chg_valid(mask_chg_valid),
        .mask_chg_pin  (mask_chg_pin),
        .mask_chg_val  (mask_chg_val),
        .svc_valid     (svc_valid),
        .svc_pin       (svc_pin)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_out
        assign tbl_out[i*ENT_W +: ENT_W] = ents[i];
    end

    // Select and identifier registers
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            id_q  <= '0;
        end else begin
            if (sel_wr) begin
                sel_q <= req_wdata;
            end
            if (id_wr) begin
                id_q <= req_wdata[27:24];
            end
        end
    end

    assign id_word = {4'h0, id_q, 24'h000000};

    always_comb begin
        unique case (tgt)
            TGT_ID:  win_word = id_word;
            TGT_ARB: win_word = id_word;
            TGT_VER: win_word = VER_WORD;
            TGT_ENT: win_word = ent_read_half(cur_ent, ent_hi);
            default: win_word = '0;
        endcase
    end

    always_comb begin
        unique case (ofs_kind)
            OK_SELECT: rd_word = sel_q;
            OK_WINDOW: rd_word = win_word;
            default:   rd_word = '0;
        endcase
    end

    // Response one cycle after a claimed access
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= claim;
            rsp_rdata <= (claim && !req_write) ? rd_word : '0;
        end
    end

endmodule

// File: rtl/irq_route_regs_chk.sv
module irq_route_regs_chk #(
    parameter int  NPINS = 24,
    localparam int IDX_W = $clog2(NPINS)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic                 req_write,
    input logic [3:0]           req_size,
    input logic [NPINS-1:0]     pin_req,
    input logic [NPINS*64-1:0]  tbl_out,
    input logic                 rsp_valid,
    input logic                 mask_chg_valid,
    input logic [IDX_W-1:0]     mask_chg_pin,
    input logic                 mask_chg_val,
    input logic                 svc_valid,
    input logic [IDX_W-1:0]     svc_pin
);

    function automatic logic all_masked(logic [NPINS*64-1:0] t);
        logic r;
        r = 1'b1;
        for (int i = 0; i < NPINS; i++) begin
            r = r & t[i*64 + 16];
        end
        return r;
    endfunction

    AST_RESET_MASKED: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> all_masked(tbl_out)); // R1

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid)); // R11

    AST_MASK_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        mask_chg_valid |-> $past(req_valid && req_write && (req_size == 4'd4 || req_size == 4'd8))); // R8

    AST_MASK_MATCHES_TABLE: assert property (@(posedge clk) disable iff (rst)
        mask_chg_valid |-> (tbl_out[int'(mask_chg_pin)*64 + 16] == mask_chg_val)); // R9

    AST_MASK_PIN_RANGE: assert property (@(posedge clk) disable iff (rst)
        mask_chg_valid |-> (int'(mask_chg_pin) < NPINS)); // R7

    AST_SVC_LEVEL_ONLY: assert property (@(posedge clk) disable iff (rst)
        svc_valid |-> tbl_out[int'(svc_pin)*64 + 15]); // R10

    AST_SVC_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        svc_valid |-> ((($past(pin_req) >> svc_pin) & NPINS'(1)) != '0)); // R10

endmodule

bind irq_route_regs irq_route_regs_chk #(.NPINS(NPINS)) u_chk (.*);

// File: tb/irq_route_regs_tb.sv
module irq_route_regs_tb;

    localparam int          NP   = 24;
    localparam int          IW   = $clog2(NP);
    localparam logic [31:0] BASE = 32'h4000_1000;
    localparam logic [31:0] VERW = 32'h0017_0011;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_valid = 1'b0;
    logic            req_write = 1'b0;
    logic [31:0]     req_addr = '0;
    logic [3:0]      req_size = '0;
    logic [31:0]     req_wdata = '0;
    logic            rsp_valid;
    logic [31:0]     rsp_rdata;
    logic [NP-1:0]   pin_req = '0;
    logic [NP-1:0]   rp_set = '0;
    logic [NP-1:0]   rp_clr = '0;
    logic [NP*64-1:0] tbl_out;
    logic            mask_chg_valid;
    logic [IW-1:0]   mask_chg_pin;
    logic            mask_chg_val;
    logic            svc_valid;
    logic [IW-1:0]   svc_pin;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 0;

    // Reference model
    logic [63:0] m_ent [NP];
    logic [31:0] m_sel;
    logic [3:0]  m_id;

    irq_route_regs u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .pin_req(pin_req), .rp_set(rp_set), .rp_clr(rp_clr),
        .tbl_out(tbl_out),
        .mask_chg_valid(mask_chg_valid), .mask_chg_pin(mask_chg_pin),
        .mask_chg_val(mask_chg_val),
        .svc_valid(svc_valid), .svc_pin(svc_pin)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [31:0] m_window();
        logic [31:0] idx;
        if (m_sel == 0 || m_sel == 2) return {4'h0, m_id, 24'h0};
        if (m_sel == 1) return VERW;
        if (m_sel < 32'h10) return 32'h0;
        idx = (m_sel - 32'h10) >> 1;
        if (idx >= NP) return 32'h0;
        return m_sel[0] ? m_ent[idx][63:32] : m_ent[idx][31:0];
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] ofs);
        if (ofs == 8'h00) return m_sel;
        if (ofs == 8'h10) return m_window();
        return 32'h0;
    endfunction

    // One bus cycle with optional delivery-side flag strobes
    task automatic cyc(input logic v, input logic w, input logic [31:0] a,
                       input logic [3:0] sz, input logic [31:0] d,
                       input logic [NP-1:0] rs, input logic [NP-1:0] rc);
        @(negedge clk);
        req_valid = v; req_write = w; req_addr = a; req_size = sz; req_wdata = d;
        rp_set = rs; rp_clr = rc;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; rp_set = '0; rp_clr = '0;
    endtask

    task automatic m_flags(input logic [NP-1:0] rs, input logic [NP-1:0] rc);
        for (int i = 0; i < NP; i++) begin
            if (rs[i]) m_ent[i][14] = 1'b1;
            if (rc[i]) m_ent[i][14] = 1'b0;
        end
    endtask

    task automatic do_write(input string tag, input logic [7:0] ofs, input logic [3:0] sz,
                            input logic [31:0] d, input logic [NP-1:0] rs,
                            input logic [NP-1:0] rc);
        logic        emv, esv, emval;
        int          epin;
        logic [31:0] idx;
        logic [63:0] nv;
        emv = 0; esv = 0; emval = 0; epin = 0;
        m_flags(rs, rc);
        if (sz == 4 || sz == 8) begin
            if (ofs == 8'h00) begin
                m_sel = d;
            end else if (ofs == 8'h10) begin
                if (m_sel == 0) begin
                    m_id = d[27:24];
                end else if (m_sel >= 32'h10) begin
                    idx = (m_sel - 32'h10) >> 1;
                    if (idx < NP) begin
                        nv = m_ent[idx];
                        if (m_sel[0]) nv[63:32] = d;
                        else begin nv[31:0] = d; nv[14] = 1'b0; end
                        epin = int'(idx);
                        emv = (nv[16] != m_ent[idx][16]);
                        emval = nv[16];
                        esv = nv[15] && pin_req[idx];
                        m_ent[idx] = nv;
                    end
                end
            end
        end
        cyc(1, 1, BASE + {24'h0, ofs}, sz, d, rs, rc);
        chk({tag, " R11 wr rsp"}, {63'h0, rsp_valid}, 64'h1);
        chk({tag, " R9 pulse"}, {63'h0, mask_chg_valid}, {63'h0, emv});
        if (emv) begin
            chk({tag, " R9 pin"}, {59'h0, mask_chg_pin}, 64'(epin));
            chk({tag, " R9 val"}, {63'h0, mask_chg_val}, {63'h0, emval});
        end
        chk({tag, " R10 svc"}, {63'h0, svc_valid}, {63'h0, esv});
        if (esv) chk({tag, " R10 svc pin"}, {59'h0, svc_pin}, 64'(epin));
    endtask

    task automatic do_read(input string tag, input logic [7:0] ofs);
        logic [31:0] exp;
        exp = m_read(ofs);
        cyc(1, 0, BASE + {24'h0, ofs}, 4'd4, 32'h0, '0, '0);
        chk({tag, " R11 rd rsp"}, {63'h0, rsp_valid}, 64'h1);
        chk({tag, " rdata"}, {32'h0, rsp_rdata}, {32'h0, exp});
    endtask

    task automatic sel_read(input string tag, input logic [31:0] s);
        do_write({tag, " sel"}, 8'h00, 4'd4, s, '0, '0);
        do_read(tag, 8'h10);
    endtask

    initial begin
        int unsigned seed;
        seed = 32'd12345;
        void'($urandom(seed));
        for (int i = 0; i < NP; i++) m_ent[i] = 64'h0000_0000_0001_0000;
        m_sel = 0; m_id = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        do_read("R1 select", 8'h00);
        do_read("R1 id", 8'h10);
        sel_read("R1 entry0 lo", 32'h10);
        sel_read("R1 entry23 hi", 32'h3F);
        sel_read("R1 entry23 lo", 32'h3E);

        // R3 version, write ignored
        sel_read("R3 version", 32'h01);
        do_write("R3 ver wr", 8'h10, 4'd4, 32'hFFFF_FFFF, '0, '0);
        do_read("R3 after wr", 8'h10);

        // R4 identifier and arbitration identifier
        do_write("R4 sel", 8'h00, 4'd4, 32'h0, '0, '0);
        do_write("R4 id wr", 8'h10, 4'd4, 32'hFA5A_5A5A, '0, '0);
        do_read("R4 id rd", 8'h10);
        do_write("R4 arb sel", 8'h00, 4'd4, 32'h2, '0, '0);
        do_write("R4 arb wr", 8'h10, 4'd4, 32'h0300_0000, '0, '0);
        do_read("R4 arb rd", 8'h10);

        // R2 other offsets
        do_read("R2 ofs 04", 8'h04);
        do_write("R2 ofs 20 wr", 8'h20, 4'd4, 32'h1234_5678, '0, '0);
        do_read("R2 ofs 20", 8'h20);
        do_read("R2 select intact", 8'h00);

        // R7 gap and beyond-table
        sel_read("R7 gap 05", 32'h05);
        do_write("R7 sel 40", 8'h00, 4'd4, 32'h40, '0, '0);
        do_write("R7 wr 40", 8'h10, 4'd4, 32'h0000_8000, '0, '0);
        do_read("R7 rd 40", 8'h10);

        // R5, R9, R10: entry 3 low half, unmask, level, request high
        pin_req = 24'h000008;
        do_write("R5 sel 16", 8'h00, 4'd4, 32'h16, '0, '0);
        do_write("R10 level unmask", 8'h10, 4'd4, 32'h0000_A031, '0, '0);
        do_read("R5 rd lo", 8'h10);
        do_write("R9 same mask", 8'h10, 4'd4, 32'h0000_A032, '0, '0);
        do_write("R10 edge", 8'h10, 4'd4, 32'h0001_2033, '0, '0);
        do_write("R5 sel 17", 8'h00, 4'd4, 32'h17, '0, '0);
        do_write("R5 hi wr", 8'h10, 4'd8, 32'hC300_0000, '0, '0);
        do_read("R5 rd hi", 8'h10);

        // R12, R6 remote-pending
        do_write("R12 set", 8'h00, 4'd4, 32'h16, 24'h000008, '0);
        do_read("R12 set rd", 8'h10);
        do_write("R6 hi keeps", 8'h00, 4'd4, 32'h17, '0, '0);
        do_write("R6 hi wr", 8'h10, 4'd4, 32'h0000_0000, '0, '0);
        sel_read("R6 lo after hi", 32'h16);
        do_write("R6 lo clears", 8'h10, 4'd4, 32'h0001_4033, '0, '0);
        do_read("R6 lo rd", 8'h10);
        do_write("R12 set+clr", 8'h00, 4'd4, 32'h16, 24'h000008, 24'h000008);
        do_read("R12 clr wins", 8'h10);
        do_write("R12 set again", 8'h00, 4'd4, 32'h16, 24'h000008, '0);
        do_write("R12 collide", 8'h10, 4'd4, 32'h0001_4033, 24'h000008, '0);
        do_read("R12 collide rd", 8'h10);

        // R8 bad sizes
        do_write("R8 size1", 8'h10, 4'd1, 32'h0000_0000, '0, '0);
        do_write("R8 size2", 8'h10, 4'd2, 32'h0000_0000, '0, '0);
        do_read("R8 unchanged", 8'h10);

        // R11 outside window
        cyc(1, 1, BASE - 32'd16, 4'd4, 32'h10, '0, '0);
        chk("R11 below no rsp", {63'h0, rsp_valid}, 64'h0);
        cyc(1, 1, BASE + 32'h100, 4'd4, 32'h10, '0, '0);
        chk("R11 above no rsp", {63'h0, rsp_valid}, 64'h0);
        do_read("R11 select intact", 8'h00);

        // R13 table export layout for entry 3
        chk("R13 tbl_out", tbl_out[3*64 +: 64], m_ent[3]);

        // Random mix
        for (int n = 0; n < 1500; n++) begin
            int unsigned op;
            logic [NP-1:0] rs, rc;
            op = $urandom % 10;
            case (op)
                0: do_write("R5 rnd sel", 8'h00, 4'd4, $urandom % 80, '0, '0);
                1, 2: do_write("R5 rnd win", 8'h10, 4'd4, $urandom, '0, '0);
                3: do_read("R5 rnd rd", 8'h10);
                4: do_read("R2 rnd sel rd", 8'h00);
                5: begin
                    logic [7:0] o;
                    o = 8'($urandom);
                    if (o == 8'h00 || o == 8'h10) o = 8'h44;
                    if ($urandom % 2 == 0) do_read("R2 rnd other", o);
                    else do_write("R2 rnd other wr", o, 4'd4, $urandom, '0, '0);
                end
                6: do_write("R8 rnd size", 8'h10, 4'(($urandom % 3) + 1) & 4'h3, $urandom, '0, '0);
                7: begin
                    cyc(1, $urandom % 2 == 0, BASE + 32'h200 + ($urandom % 64), 4'd4, $urandom, '0, '0);
                    chk("R11 rnd outside", {63'h0, rsp_valid}, 64'h0);
                end
                8: begin
                    @(negedge clk);
                    pin_req = NP'($urandom);
                end
                default: begin
                    rs = NP'($urandom);
                    rc = NP'($urandom) & NP'($urandom);
                    do_write("R12 rnd flags", 8'h00, 4'd4, $urandom % 80, rs, rc);
                end
            endcase
        end
        for (int i = 0; i < NP; i++) chk("R13 final table", tbl_out[i*64 +: 64], m_ent[i]);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule